// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block takes a small set of external interrupt pins and turns each into an interrupt source. Every pin has its own function selector that routes it to the interrupt logic or blocks it, its own trigger mode, its own sub-pending flag and its own sub-mask bit. The low pins each own one bit of the main pending register. The upper pins are folded together into a single shared main bit, so an event there must pass both its own sub-mask and the shared main mask before the interrupt output rises.

Each pin passes a two-flop synchronizer and one history flop. Level modes show pending for as long as the pin holds its active level. Edge modes set a sticky flag that software clears by writing 1. All configuration and status goes through a flat word-addressed register port. Writes take effect on the clock edge and reads are combinational.

Top module: `eint_group_ctrl`

## Requirements
- R1: After reset, every function field and trigger field reads 0, all sub-pending bits read 0, sub-mask reads all ones, the main mask reads all ones, main pending reads 0 and `irq_o` is 0. Register word addresses are: 0 function (2 bits per line, line n at bits [2n+1:2n]), 1 trigger (3 bits per line at bits [4n+2:4n]), 2 sub-pending, 3 sub-mask, 4 main pending (read only), 5 main mask.
- R2: A line whose function field is not 2'b10 produces no new pending, in any trigger mode and for any pin activity. Setting the field to 2'b10 connects the line.
- R3: Trigger 3'b000 makes a line pending while its synchronized pin is low. Trigger 3'b001 makes it pending while the pin is high. The level appears two clocks after the pin changes.
- R4: Trigger codes 01x capture falling edges, 10x capture rising edges and 11x capture both. A captured edge sets a sticky sub-pending bit one clock after the level would appear.
- R5: Writing 1 to a sub-pending bit clears a sticky edge flag. Writing 0 has no effect. A level-mode pending bit is not affected by the write.
- R6: For lines below 4, main pending bit n equals sub-pending n AND NOT sub-mask n.
- R7: Main pending bit 4 is the OR over lines 4 to 7 of (sub-pending AND NOT sub-mask).
- R8: `irq_o` is the OR over main pending bits whose main mask bit is 0. It is 0 whenever the whole main mask is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_LINES | External interrupt pins, asynchronous |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench uses the default eight lines with the group starting at line 4. This makes the whole configuration space small enough to sweep. Every line is run through all eight trigger codes with falling and rising pin transitions and both forms of clear write. The function gate is tried with each of its three blocking values. All sixteen sub-mask patterns over the folded group are applied against a fixed set of pending lines, so the group summary is checked against every combination.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam logic [2:0] A_FUNC     = 3'd0;
  localparam logic [2:0] A_TRIG     = 3'd1;
  localparam logic [2:0] A_SUBPEND  = 3'd2;
  localparam logic [2:0] A_SUBMASK  = 3'd3;
  localparam logic [2:0] A_MAINPEND = 3'd4;
  localparam logic [2:0] A_MAINMASK = 3'd5;

  localparam logic [1:0] FUNC_EINT = 2'b10;

  typedef enum logic [1:0] {
    TK_LEVEL = 2'b00,
    TK_FALL  = 2'b01,
    TK_RISE  = 2'b10,
    TK_BOTH  = 2'b11
  } trig_kind_e;

  function automatic trig_kind_e trig_kind(input logic [2:0] code);
    return trig_kind_e'(code[2:1]);
  endfunction
endpackage

// File: rtl/eint_line.sv
module eint_line
  import eint_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       en_i,
  input  logic [2:0] mode_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic s1_q, s2_q, hist_q, sticky_q;
  logic rise, fall, evt, lvl, is_lvl, set_c;
  trig_kind_e kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      hist_q <= s2_q;
    end
  end

  always_comb begin
    kind   = trig_kind(mode_i);
    is_lvl = (kind == TK_LEVEL);
    rise   = s2_q & ~hist_q;
    fall   = ~s2_q & hist_q;
    lvl    = mode_i[0] ? s2_q : ~s2_q;
    unique case (kind)
      TK_FALL: evt = fall;
      TK_RISE: evt = rise;
      TK_BOTH: evt = rise | fall;
      default: evt = 1'b0;
    endcase
    set_c = en_i & ~is_lvl & evt;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sticky_q <= 1'b0;
    else if (set_c)  sticky_q <= 1'b1;
    else if (clr_i)  sticky_q <= 1'b0;
  end

  assign pend_o = is_lvl ? (en_i & lvl) : sticky_q;

  // R4
  edge_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !is_lvl && evt) |=> sticky_q);
  // R5
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(en_i && !is_lvl && evt)) |=> !sticky_q);
  // R2
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> (sticky_q == $past(sticky_q)));
endmodule

// File: rtl/eint_fold.sv
module eint_fold #(
  parameter int NUM_LINES = 8,
  parameter int GRP_LO    = 4,
  localparam int NUM_MAIN = GRP_LO + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] sub_pend_i,
  input  logic [NUM_LINES-1:0] sub_mask_i,
  input  logic [NUM_MAIN-1:0]  main_mask_i,
  output logic [NUM_MAIN-1:0]  main_pend_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] live;
  assign live = sub_pend_i & ~sub_mask_i;

  for (genvar i = 0; i < GRP_LO; i++) begin : g_direct
    assign main_pend_o[i] = live[i];
  end
  assign main_pend_o[GRP_LO] = |live[NUM_LINES-1:GRP_LO];

  assign irq_o = |(main_pend_o & ~main_mask_i);

  // R7
  group_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sub_pend_i[NUM_LINES-1:GRP_LO] & ~sub_mask_i[NUM_LINES-1:GRP_LO]) == '0)
      |-> !main_pend_o[GRP_LO]);
  // R8
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&main_mask_i) |-> !irq_o);
  // R6
  direct_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sub_mask_i[GRP_LO-1:0] & main_pend_o[GRP_LO-1:0]) == '0));
endmodule

// File: rtl/eint_group_ctrl.sv
module eint_group_ctrl
  import eint_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int GRP_LO    = 4,
  parameter int DW        = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic                 we_i,
  input  logic [2:0]           addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 irq_o
);
  localparam int NUM_MAIN = GRP_LO + 1;
  localparam int TSTRIDE  = 4;

  logic [NUM_LINES-1:0][1:0] func_q;
  logic [NUM_LINES-1:0][2:0] trig_q;
  logic [NUM_LINES-1:0]      sub_mask_q;
  logic [NUM_MAIN-1:0]       main_mask_q;
  logic [NUM_LINES-1:0]      sub_pend, clr;
  logic [NUM_MAIN-1:0]       main_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_q      <= '0;
      trig_q      <= '0;
      sub_mask_q  <= '1;
      main_mask_q <= '1;
    end else if (we_i) begin
      unique case (addr_i)
        A_FUNC:
          for (int i = 0; i < NUM_LINES; i++) func_q[i] <= wdata_i[2*i +: 2];
        A_TRIG:
          for (int i = 0; i < NUM_LINES; i++) trig_q[i] <= wdata_i[TSTRIDE*i +: 3];
        A_SUBMASK:  sub_mask_q  <= wdata_i[NUM_LINES-1:0];
        A_MAINMASK: main_mask_q <= wdata_i[NUM_MAIN-1:0];
        default: ;
      endcase
    end
  end

  assign clr = (we_i && addr_i == A_SUBPEND) ? wdata_i[NUM_LINES-1:0] : '0;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    eint_line u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[i]),
      .en_i   (func_q[i] == FUNC_EINT),
      .mode_i (trig_q[i]),
      .clr_i  (clr[i]),
      .pend_o (sub_pend[i])
    );
  end

  eint_fold #(.NUM_LINES(NUM_LINES), .GRP_LO(GRP_LO)) u_fold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sub_pend_i  (sub_pend),
    .sub_mask_i  (sub_mask_q),
    .main_mask_i (main_mask_q),
    .main_pend_o (main_pend),
    .irq_o       (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_FUNC:
        for (int i = 0; i < NUM_LINES; i++) rdata_o[2*i +: 2] = func_q[i];
      A_TRIG:
        for (int i = 0; i < NUM_LINES; i++) rdata_o[TSTRIDE*i +: 3] = trig_q[i];
      A_SUBPEND:  rdata_o[NUM_LINES-1:0] = sub_pend;
      A_SUBMASK:  rdata_o[NUM_LINES-1:0] = sub_mask_q;
      A_MAINPEND: rdata_o[NUM_MAIN-1:0]  = main_pend;
      A_MAINMASK: rdata_o[NUM_MAIN-1:0]  = main_mask_q;
      default: ;
    endcase
  end

  // R1
  mask_reset_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!irq_o && main_mask_q == '1));
endmodule

// File: tb/eint_group_ctrl_tb.sv
`timescale 1ns/1ps
module eint_group_ctrl_tb;
  localparam int N = 8;
  logic clk = 0, rst_n = 0, we = 0;
  logic [N-1:0] pins = '1;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  eint_group_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // compares one line's sub-pending, main bit and irq against the model
  task automatic look(input string req, input int ln, input logic exp);
    logic [31:0] v;
    int mb;
    mb = (ln < 4) ? ln : 4;
    rd(3'd2, v); chk({req, " subpend"}, 32'(v[ln]), 32'(exp));
    rd(3'd4, v); chk({req, " mainpend"}, 32'(v[mb]), 32'(exp));
    #1; chk({req, " irq"}, 32'(irq), 32'(exp));
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd(3'd0, v); chk("R1 func", v, 0);
    rd(3'd1, v); chk("R1 trig", v, 0);
    rd(3'd2, v); chk("R1 subpend", v, 0);
    rd(3'd3, v); chk("R1 submask", v, 32'hFF);
    rd(3'd4, v); chk("R1 mainpend", v, 0);
    rd(3'd5, v); chk("R1 mainmask", v, 32'h1F);
    chk("R1 irq", 32'(irq), 0);

    // R3 R4 R5 sweep: every line, every trigger code
    for (int ln = 0; ln < N; ln++) begin
      for (int code = 0; code < 8; code++) begin
        logic sticky, prev, lvlmode, m;
        logic [1:0] k;
        lvlmode = (code[2:1] == 2'b00);
        k = code[2:1];
        wr(3'd0, 32'd2 << (2*ln));
        wr(3'd1, 32'(code) << (4*ln));
        wr(3'd3, ~(32'd1 << ln) & 32'hFF);
        wr(3'd5, 0);
        settle();
        wr(3'd2, 32'hFF);
        sticky = 0; prev = 1;
        look(lvlmode ? "R3 idle" : "R4 idle", ln, lvlmode ? code[0] : 1'b0);
        for (int s = 0; s < 2; s++) begin
          logic nv;
          nv = (s == 0) ? 1'b0 : 1'b1;
          @(negedge clk); pins[ln] = nv;
          settle();
          m = ((k == 2'b01 || k == 2'b11) && prev && !nv) ||
              ((k == 2'b10 || k == 2'b11) && !prev && nv);
          sticky = sticky | m;
          prev = nv;
          look(lvlmode ? "R3 level" : "R4 edge", ln,
               lvlmode ? (code[0] ? nv : ~nv) : sticky);
        end
        wr(3'd2, 0);
        look("R5 zero write", ln, lvlmode ? code[0] : sticky);
        wr(3'd2, 32'd1 << ln);
        look("R5 clear", ln, lvlmode ? code[0] : 1'b0);
      end
    end
    wr(3'd0, 0); wr(3'd1, 0); settle(); wr(3'd2, 32'hFF);

    // R2 function gate, line 5 both edges
    wr(3'd1, 32'd6 << 20);
    wr(3'd3, 32'hDF);
    for (int f = 0; f < 4; f++) begin
      if (f == 2) continue;
      wr(3'd0, 32'(f) << 10);
      @(negedge clk); pins[5] = 0; settle();
      @(negedge clk); pins[5] = 1; settle();
      rd(3'd2, v); chk("R2 gated edge", 32'(v[5]), 0);
    end
    wr(3'd1, 0);
    wr(3'd0, 32'd1 << 10);
    @(negedge clk); pins[5] = 0; settle();
    rd(3'd2, v); chk("R2 gated level", 32'(v[5]), 0);
    wr(3'd0, 32'd2 << 10); @(negedge clk);
    rd(3'd2, v); chk("R2 enabled level", 32'(v[5]), 1);
    @(negedge clk); pins[5] = 1; settle();
    wr(3'd0, 0);

    // R6 R8 line 2 low level held
    wr(3'd0, 32'd2 << 4);
    @(negedge clk); pins[2] = 0; settle();
    wr(3'd3, 32'hFF); wr(3'd5, 0);
    rd(3'd2, v); chk("R6 subpend visible", 32'(v[2]), 1);
    rd(3'd4, v); chk("R6 masked main", v, 0);
    chk("R6 irq", 32'(irq), 0);
    wr(3'd3, 32'hFB);
    rd(3'd4, v); chk("R6 unmasked main", v, 32'h4);
    chk("R8 irq on", 32'(irq), 1);
    wr(3'd5, 32'h04); #1;
    rd(3'd4, v); chk("R8 main still pend", v, 32'h4);
    chk("R8 irq masked", 32'(irq), 0);
    wr(3'd5, 32'h1B); #1; chk("R8 other bits masked", 32'(irq), 1);
    wr(3'd5, 32'h1F); #1; chk("R8 all masked", 32'(irq), 0);
    @(negedge clk); pins[2] = 1; settle();
    wr(3'd0, 0);

    // R7 group fold: lines 4 and 6 hold falling-edge flags
    wr(3'd1, (32'd2 << 16) | (32'd2 << 24));
    wr(3'd0, (32'd2 << 8) | (32'd2 << 12));
    wr(3'd2, 32'hFF);
    @(negedge clk); pins[4] = 0; pins[6] = 0; settle();
    @(negedge clk); pins[4] = 1; pins[6] = 1; settle();
    wr(3'd5, 0);
    for (int m = 0; m < 16; m++) begin
      logic e;
      e = |(4'b0101 & ~m[3:0]);
      wr(3'd3, {24'd0, m[3:0], 4'hF});
      rd(3'd4, v); chk("R7 group bit", v, {27'd0, e, 4'd0});
      chk("R7 irq", 32'(irq), 32'(e));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule